// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block produces the five condition flags of a 32-bit integer core (negative, zero, overflow, carry and extend) from a deferred record. Instead of carrying both ALU operands forward, the datapath records only an operation kind, the result word and one source operand. The evaluator rebuilds the missing operand from those two words and derives the flags.

A record is presented with a one-cycle valid strobe. The flags update on the following clock edge. The kinds cover a direct flag load, logical results, 32-bit add and subtract, 8-bit and 16-bit compare, shifts, and the add and subtract with extend used for multi-word arithmetic. The extended kinds read the current extend flag to pick an inclusive or strict carry test. They also keep a zero flag that can only be cleared, so a chain of words tests zero across the whole value. An unknown kind code is reported by a one-cycle error pulse.

Top module: `ccflag_eval`

## Requirements
- R1: An active-low synchronous reset clears all five flags and the error output.
- R2: Kind codes are: 0 direct load, 1 logic, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add with extend, 7 subtract with extend, 8 shift. Flags change only on the clock edge after a cycle with `op_vld` high. Without a strobe they hold their value.
- R3: Direct load (0) sets N, Z, V and C from `op_res` bits 3, 2, 1 and 0 respectively and leaves X unchanged.
- R4: Logic (1) sets Z when the result is zero and N from result bit 31, and clears V and C. X is unchanged.
- R5: Shift (8) sets N and Z as in R4, clears V, and sets both C and X when `op_src` is nonzero.
- R6: Add (2) sets C when the result is unsigned-below the source and V when the signed sum of the rebuilt addend and the source overflows. X takes the value of C.
- R7: Subtract (3) rebuilds the minuend as result plus source. C is set when the minuend is unsigned-below the source, and V is set on signed overflow of the subtraction. X takes the value of C.
- R8: Byte (4) and word (5) compare apply the R7 rule to the low 8 or 16 bits, with N and Z taken from the truncated result. X is unchanged.
- R9: Add with extend (6) uses the R6 rule when X is clear. When X is set, the rebuilt addend also subtracts one and C is set when the result is below or equal to the source. X takes the value of C.
- R10: Subtract with extend (7) uses the R7 rule when X is clear. When X is set, the rebuilt minuend also adds one and C is set when the minuend is below or equal to the source. X takes the value of C.
- R11: For kinds 6 and 7, the new Z is the zero test of the result ANDed with the previous Z.
- R12: Kind codes 9 to 15 leave all flags unchanged and raise `kind_err` for exactly the one cycle that follows the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Record valid strobe |
| op_kind | input | 4 | Operation kind code |
| op_res | input | 32 | Recorded result word |
| op_src | input | 32 | Recorded source operand |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_x | output | 1 | Extend flag |
| kind_err | output | 1 | Undefined kind pulse |

## Verification
The only internal state is the flag register, and X and Z also feed back into the extended kinds. A wrong stored X therefore shows one record later, as a carry that is off by one at the inclusive boundary. A wrong stored Z shows as a multi-word zero test that never recovers until a direct load. The stimulus places extended operations straight after records that set or clear X and Z, and hits the inclusive limits where the result equals the source. Every flag is compared on the cycle after each strobe, so a fault shows within one record of its cause.

// File: rtl/ccflag_eval.sv
module ccflag_eval (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_vld,
  input  logic [3:0]  op_kind,
  input  logic [31:0] op_res,
  input  logic [31:0] op_src,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c,
  output logic        flag_x,
  output logic        kind_err
);
  localparam logic [3:0] K_LOAD = 4'd0, K_LOGIC = 4'd1, K_ADD = 4'd2, K_SUB = 4'd3,
                         K_CMPB = 4'd4, K_CMPW = 4'd5, K_ADDX = 4'd6, K_SUBX = 4'd7,
                         K_SHIFT = 4'd8;

  logic        xin_a, xin_s;
  logic [31:0] addend, minuend;
  logic [7:0]  min8;
  logic [15:0] min16;
  logic        add_c, add_v, sub_c, sub_v;
  logic        b_c, b_v, w_c, w_v;
  logic        res_z;

  assign xin_a   = (op_kind == K_ADDX) & flag_x;
  assign xin_s   = (op_kind == K_SUBX) & flag_x;
  assign res_z   = (op_res == 32'd0);

  assign addend  = op_res - op_src - {31'd0, xin_a};
  assign add_c   = xin_a ? (op_res <= op_src) : (op_res < op_src);
  assign add_v   = (op_src[31] ^ op_res[31]) & ~(addend[31] ^ op_src[31]);

  assign minuend = op_res + op_src + {31'd0, xin_s};
  assign sub_c   = xin_s ? (minuend <= op_src) : (minuend < op_src);
  assign sub_v   = (minuend[31] ^ op_res[31]) & (minuend[31] ^ op_src[31]);

  assign min8    = op_res[7:0] + op_src[7:0];
  assign b_c     = min8 < op_src[7:0];
  assign b_v     = (min8[7] ^ op_res[7]) & (min8[7] ^ op_src[7]);

  assign min16   = op_res[15:0] + op_src[15:0];
  assign w_c     = min16 < op_src[15:0];
  assign w_v     = (min16[15] ^ op_res[15]) & (min16[15] ^ op_src[15]);

  logic nn, nz, nv, nc, nx, bad;

  always_comb begin
    nn  = op_res[31];
    nz  = res_z;
    nv  = 1'b0;
    nc  = 1'b0;
    nx  = flag_x;
    bad = 1'b0;
    case (op_kind)
      K_LOAD:  begin nn = op_res[3]; nz = op_res[2]; nv = op_res[1]; nc = op_res[0]; end
      K_LOGIC: ;
      K_ADD:   begin nv = add_v; nc = add_c; nx = add_c; end
      K_SUB:   begin nv = sub_v; nc = sub_c; nx = sub_c; end
      K_CMPB:  begin nn = op_res[7];  nz = (op_res[7:0] == 8'd0);   nv = b_v; nc = b_c; end
      K_CMPW:  begin nn = op_res[15]; nz = (op_res[15:0] == 16'd0); nv = w_v; nc = w_c; end
      K_ADDX:  begin nz = res_z & flag_z; nv = add_v; nc = add_c; nx = add_c; end
      K_SUBX:  begin nz = res_z & flag_z; nv = sub_v; nc = sub_c; nx = sub_c; end
      K_SHIFT: begin nc = (op_src != 32'd0); nx = nc; end
      default: begin
        nn = flag_n; nz = flag_z; nv = flag_v; nc = flag_c; bad = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {flag_n, flag_z, flag_v, flag_c, flag_x} <= 5'd0;
      kind_err <= 1'b0;
    end else begin
      kind_err <= op_vld & bad;
      if (op_vld) {flag_n, flag_z, flag_v, flag_c, flag_x} <= {nn, nz, nv, nc, nx};
    end
  end
endmodule

// File: rtl/ccflag_eval_chk.sv
module ccflag_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_vld,
  input logic [3:0]  op_kind,
  input logic [31:0] op_res,
  input logic [31:0] op_src,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_v,
  input logic        flag_c,
  input logic        flag_x,
  input logic        kind_err
);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> $stable({flag_n, flag_z, flag_v, flag_c, flag_x}) && !kind_err);

  // R12
  undef_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_kind > 4'd8) |=> kind_err && $stable({flag_n, flag_z, flag_v, flag_c, flag_x}));

  // R4
  logic_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_kind == 4'd1) |=> !flag_v && !flag_c && !(flag_n && flag_z));

  // R11
  sticky_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && (op_kind == 4'd6 || op_kind == 4'd7) && !flag_z) |=> !flag_z);

  // R8
  cmp_keep_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && (op_kind == 4'd4 || op_kind == 4'd5)) |=> $stable(flag_x));

  // R5
  shift_cx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_kind == 4'd8) |=> (flag_c == flag_x) && !flag_v);
endmodule

bind ccflag_eval ccflag_eval_chk u_chk (.*);

// File: tb/ccflag_eval_tb.sv
module ccflag_eval_tb;
  logic clk = 1'b0, rst_n = 1'b0, op_vld = 1'b0;
  logic [3:0]  op_kind = 4'd0;
  logic [31:0] op_res = 32'd0, op_src = 32'd0;
  logic flag_n, flag_z, flag_v, flag_c, flag_x, kind_err;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ccflag_eval u_dut (.*);

  typedef struct { logic [5:0] exp; string tag; } item_t;
  item_t q[$];
  logic mn = 0, mz = 0, mv = 0, mc = 0, mx = 0;
  logic samp = 0;

  always @(posedge clk) samp <= op_vld;

  always @(negedge clk) begin
    if (rst_n && samp && q.size() > 0) begin
      item_t it;
      logic [5:0] act;
      it = q.pop_front();
      act = {kind_err, flag_n, flag_z, flag_v, flag_c, flag_x};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: {err,n,z,v,c,x} actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  task automatic drive(input logic [3:0] k, input logic [31:0] r, input logic [31:0] s,
                       input logic err, input string tag);
    item_t it;
    it.exp = {err, mn, mz, mv, mc, mx};
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    op_vld = 1'b1; op_kind = k; op_res = r; op_src = s;
    @(negedge clk);
    op_vld = 1'b0;
  endtask

  task automatic raw(input logic [3:0] k, input logic [31:0] r, input logic [31:0] s, input string tag);
    case (k)
      4'd0: {mn, mz, mv, mc} = r[3:0];
      4'd1: begin mz = (r == 0); mn = r[31]; mv = 0; mc = 0; end
      4'd8: begin mz = (r == 0); mn = r[31]; mv = 0; mc = (s != 0); mx = mc; end
      default: ;
    endcase
    drive(k, r, s, k > 4'd8, tag);
  endtask

  task automatic arith(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [32:0] w;
    logic [31:0] r, s;
    logic cin, ext;
    ext = (k == 4'd6) || (k == 4'd7);
    cin = ext ? mx : 1'b0;
    s = b;
    if (k == 4'd2 || k == 4'd6) begin
      w = {1'b0, a} + {1'b0, b} + {32'd0, cin};
      r = w[31:0];
      mv = (a[31] == b[31]) && (r[31] != a[31]);
    end else if (k == 4'd3 || k == 4'd7) begin
      w = {1'b0, a} - {1'b0, b} - {32'd0, cin};
      r = w[31:0];
      mv = (a[31] != b[31]) && (r[31] != a[31]);
    end else if (k == 4'd4) begin
      logic [8:0] d;
      d = {1'b0, a[7:0]} - {1'b0, b[7:0]};
      r = {24'hA5A5A5, d[7:0]}; s = {24'h3C3C3C, b[7:0]};
      mv = (a[7] != b[7]) && (d[7] != a[7]);
      mc = d[8]; mn = d[7]; mz = (d[7:0] == 0);
    end else begin
      logic [16:0] d;
      d = {1'b0, a[15:0]} - {1'b0, b[15:0]};
      r = {16'h5A5A, d[15:0]}; s = {16'hC3C3, b[15:0]};
      mv = (a[15] != b[15]) && (d[15] != a[15]);
      mc = d[16]; mn = d[15]; mz = (d[15:0] == 0);
    end
    if (k != 4'd4 && k != 4'd5) begin
      mc = w[32]; mx = w[32]; mn = r[31];
      mz = ext ? ((r == 0) && mz) : (r == 0);
    end
    drive(k, r, s, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({kind_err, flag_n, flag_z, flag_v, flag_c, flag_x} !== 6'd0) begin
      errors++;
      $display("FAIL R1: reset flags actual %b expected 000000",
               {kind_err, flag_n, flag_z, flag_v, flag_c, flag_x});
    end
    raw(4'd0, 32'hFFFF_FFFA, 32'd0, "R3 direct load");
    raw(4'd1, 32'd0, 32'd7, "R4 logic zero");
    raw(4'd1, 32'h8000_0001, 32'd0, "R4 logic negative");
    raw(4'd0, 32'h0000_0001, 32'd0, "R3 set carry");
    raw(4'd1, 32'h0000_1234, 32'd0, "R4 logic clears carry");
    arith(4'd2, 32'd1, 32'd2, "R6 add small");
    arith(4'd2, 32'hFFFF_FFFF, 32'd1, "R6 add carry zero");
    arith(4'd2, 32'h7FFF_FFFF, 32'd1, "R6 add overflow");
    arith(4'd2, 32'h8000_0000, 32'h8000_0000, "R6 add carry overflow");
    arith(4'd3, 32'd5, 32'd3, "R7 sub small");
    arith(4'd3, 32'h8000_0000, 32'd1, "R7 sub overflow");
    arith(4'd3, 32'd3, 32'd5, "R7 sub borrow");
    arith(4'd4, 32'h10, 32'h20, "R8 byte compare borrow");
    arith(4'd4, 32'h80, 32'h01, "R8 byte compare overflow");
    arith(4'd4, 32'h42, 32'h42, "R8 byte compare equal");
    arith(4'd5, 32'h8000, 32'h0001, "R8 word compare overflow");
    raw(4'd8, 32'd0, 32'd0, "R5 shift zero no carry");
    raw(4'd8, 32'h8000_0000, 32'd1, "R5 shift carry out");
    raw(4'd0, 32'h4, 32'd0, "R3 preset zero for chain");
    arith(4'd6, 32'hFFFF_FFFF, 32'd0, "R9 add extend inclusive carry");
    arith(4'd6, 32'd0, 32'd0, "R9 R11 add extend clears zero");
    arith(4'd6, 32'd0, 32'd0, "R11 zero stays cleared");
    arith(4'd7, 32'd0, 32'd1, "R10 sub extend strict path");
    arith(4'd7, 32'd5, 32'd5, "R10 sub extend inclusive borrow");
    raw(4'd0, 32'h4, 32'd0, "R3 preset zero again");
    arith(4'd7, 32'd5, 32'd4, "R10 R11 sub extend zero kept");
    raw(4'd12, 32'hFFFF_FFFF, 32'd9, "R12 undefined kind");
    @(negedge clk);
    checks++;
    if (kind_err !== 1'b0) begin
      errors++;
      $display("FAIL R12: error pulse length actual %b expected 0", kind_err);
    end
    raw(4'd15, 32'd0, 32'd0, "R12 undefined top code");
    repeat (3) @(negedge clk);
    checks++;
    if ({flag_n, flag_z, flag_v, flag_c, flag_x} !== {mn, mz, mv, mc, mx}) begin
      errors++;
      $display("FAIL R2: idle hold actual %b expected %b",
               {flag_n, flag_z, flag_v, flag_c, flag_x}, {mn, mz, mv, mc, mx});
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule